// File: doc/BRIEF.md
# Chipset control register file

This block is the word-wide control register bank of a system chipset. A bus master reaches it with a single-cycle access: an access strobe, a write flag, a byte address and write data. Writes update the addressed register on the clock edge that accepts the access. Reads return their data one cycle later, marked by a read-valid pulse. The bank holds the chipset configuration, a read-only revision, the invalid-address register, the cache-maintenance register, and the I/O cache physical tag, logical tag and byte mask. It also holds sixteen remote-speed registers, an NV-RAM protect register, a local-bus interrupt mask with its sampled source, and a sticky NMI source register that the DMA channels feed.

Some accesses have side effects. A read of the timer acknowledge location lowers the timer interrupt. A write to the cache buffer window is compared against the current logical tag and byte mask. When both hold one fixed pairing, the block issues a single 32-bit memory-write request carrying the written word. The target address is built from the physical tag and the low bits of the maintenance register. An access to any offset outside the map reads as zero and raises a one-cycle error strobe.

Top module: `ccr_top`

## Requirements
- R1: After reset these registers read as follows: configuration (0x000) = 0x410, revision (0x008) = 1, NV-RAM protect (0x220) = 7, interrupt mask (0x240) = 0x10, every remote-speed register = 7. Invalid-address (0x010), maintenance (0x030), physical tag (0x048), logical tag (0x050), byte mask (0x058), NMI source (0x200) and interrupt source (0x248) read 0. The timer interrupt is low.
- R2: A write to a writable register (0x000, 0x010, 0x030, 0x048, 0x050, 0x058, 0x220, 0x240) takes effect on the accepting edge. Every accepted read drives `rdValid` high for exactly the following cycle, with the data on `busRdata` in that cycle.
- R3: The remote-speed registers are 16 independent entries at offsets 0x070 + 8*i, for i = 0 to 15 (the last one at 0x0E8).
- R4: Revision is read-only and writes to it are ignored. Offset 0x208 reads 0. Offset 0x238 reads the constant 7, and writes to it are ignored. The window (0x060) reads 0.
- R5: A write to the window at 0x060 pulses `memWrReq` for one cycle, in the cycle after acceptance, only when the logical tag equals 0x80000001 and the byte mask equals 0x0F0F0F0F at that time. `memWrData` then equals the written word.
- R6: The request address `memWrAddr` is (physical tag with bit 0 cleared) + ((maintenance & 3) << 3).
- R7: A high `timerEvent` raises `timerIrq` on the next edge. A read of 0x230 returns 0 and lowers `timerIrq` on the accepting edge. When an event arrives in the same cycle as the acknowledge, the event wins.
- R8: `dmaFault[i]` set high sets bit i of the NMI source register (0x200), and the bit stays set. A write to 0x200 clears the bits whose write-data bit is 1. A fault in the same cycle as the clear wins.
- R9: An access to an unmapped offset, including any address with bits [2:0] non-zero, changes no register. A read of such an offset returns 0. `accessErr` is high for exactly the cycle after acceptance.
- R10: The interrupt source register samples `lbIrqIn` on every edge. `lbIrq` is high when any bit of that sampled source is also set in the interrupt mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe, one access per high cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while rdValid is high |
| rdValid | output | 1 | Read data valid, the cycle after a read |
| accessErr | output | 1 | One-cycle strobe for an unmapped access |
| dmaFault | input | 8 | Per-channel DMA fault, sets NMI source bits |
| timerEvent | input | 1 | Raises the timer interrupt |
| timerIrq | output | 1 | Timer interrupt |
| lbIrqIn | input | 16 | Raw local-bus interrupt requests |
| lbIrq | output | 1 | Masked local-bus interrupt |
| memWrReq | output | 1 | One-cycle 32-bit memory-write request |
| memWrAddr | output | 32 | Address of the memory write |
| memWrData | output | 32 | Data of the memory write |

## Verification
The window side effect is tried in four cases: the matching tag and mask pairing, a changed maintenance index, a byte mask off by one bit, and a logical tag off by one bit. Together these show that the request needs both comparisons, and that the address follows the maintenance bits and ignores physical-tag bit 0. All sixteen remote-speed entries are written with distinct values and read back, so a stride or index error shows up as a wrong or aliased entry. The NMI bits, the timer interrupt and the misaligned alias of the configuration register are each tried alone and in competition with a clear. This separates sticky set-wins behaviour from plain storage, and a real unmapped access from a silent write.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int SPEED_N  = 16;
  localparam int SPEED_IW = $clog2(SPEED_N);

  localparam logic [11:0] OFF_CFG    = 12'h000;
  localparam logic [11:0] OFF_REV    = 12'h008;
  localparam logic [11:0] OFF_INV    = 12'h010;
  localparam logic [11:0] OFF_MAINT  = 12'h030;
  localparam logic [11:0] OFF_PTAG   = 12'h048;
  localparam logic [11:0] OFF_LTAG   = 12'h050;
  localparam logic [11:0] OFF_BMASK  = 12'h058;
  localparam logic [11:0] OFF_WIN    = 12'h060;
  localparam logic [11:0] OFF_SPEED0 = 12'h070;
  localparam logic [11:0] OFF_SPEEDN = 12'h0E8;
  localparam logic [11:0] OFF_NMI    = 12'h200;
  localparam logic [11:0] OFF_ERRTY  = 12'h208;
  localparam logic [11:0] OFF_NVP    = 12'h220;
  localparam logic [11:0] OFF_TACK   = 12'h230;
  localparam logic [11:0] OFF_SEVEN  = 12'h238;
  localparam logic [11:0] OFF_IMR    = 12'h240;
  localparam logic [11:0] OFF_ISR    = 12'h248;

  localparam logic [31:0] RST_CFG   = 32'h0000_0410;
  localparam logic [31:0] RST_REV   = 32'h0000_0001;
  localparam logic [31:0] RST_NVP   = 32'h0000_0007;
  localparam logic [31:0] RST_IMR   = 32'h0000_0010;
  localparam logic [31:0] RST_SPEED = 32'h0000_0007;
  localparam logic [31:0] CONST_238 = 32'h0000_0007;
  localparam logic [31:0] MAGIC_TAG = 32'h8000_0001;
  localparam logic [31:0] MAGIC_MSK = 32'h0F0F_0F0F;

  typedef enum logic [3:0] {
    RS_ZERO, RS_CFG, RS_REV, RS_INV, RS_MAINT, RS_PTAG, RS_LTAG, RS_BMASK,
    RS_SPEED, RS_NMI, RS_SEVEN, RS_NVP, RS_IMR, RS_ISR
  } rdSel_e;

  typedef struct packed {
    logic   wrCfg;
    logic   wrInv;
    logic   wrMaint;
    logic   wrPtag;
    logic   wrLtag;
    logic   wrBmask;
    logic   wrWin;
    logic   wrSpeed;
    logic   wrNvp;
    logic   wrNmiClr;
    logic   wrImr;
    logic   rdTimerAck;
    logic   rdEn;
    rdSel_e rdSel;
    logic [SPEED_IW-1:0] speedIdx;
  } strobes_t;

endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          st,
  output logic              rdValid,
  output logic              accessErr
);

  localparam logic [ADDR_W-1:0] SPEED_LO = ADDR_W'(OFF_SPEED0);
  localparam logic [ADDR_W-1:0] SPEED_HI = ADDR_W'(OFF_SPEEDN);

  logic              aligned;
  logic              inSpeed;
  logic              mapped;
  logic [ADDR_W-1:0] speedRel;
  logic              doWr;
  logic              doRd;

  assign aligned  = (busAddr[2:0] == 3'b000);
  assign inSpeed  = aligned && (busAddr >= SPEED_LO) && (busAddr <= SPEED_HI);
  assign speedRel = busAddr - SPEED_LO;
  assign doWr     = busValid && busWrite;
  assign doRd     = busValid && !busWrite;

  always_comb begin
    st          = '0;
    st.rdSel    = RS_ZERO;
    st.speedIdx = speedRel[SPEED_IW+2:3];
    mapped      = 1'b1;
    if (inSpeed) begin
      st.wrSpeed = doWr;
      st.rdSel   = RS_SPEED;
    end else begin
      unique case (busAddr)
        ADDR_W'(OFF_CFG):   begin st.wrCfg   = doWr; st.rdSel = RS_CFG;   end
        ADDR_W'(OFF_REV):   st.rdSel = RS_REV;
        ADDR_W'(OFF_INV):   begin st.wrInv   = doWr; st.rdSel = RS_INV;   end
        ADDR_W'(OFF_MAINT): begin st.wrMaint = doWr; st.rdSel = RS_MAINT; end
        ADDR_W'(OFF_PTAG):  begin st.wrPtag  = doWr; st.rdSel = RS_PTAG;  end
        ADDR_W'(OFF_LTAG):  begin st.wrLtag  = doWr; st.rdSel = RS_LTAG;  end
        ADDR_W'(OFF_BMASK): begin st.wrBmask = doWr; st.rdSel = RS_BMASK; end
        ADDR_W'(OFF_WIN):   st.wrWin = doWr;
        ADDR_W'(OFF_NMI):   begin st.wrNmiClr = doWr; st.rdSel = RS_NMI;  end
        ADDR_W'(OFF_ERRTY): st.rdSel = RS_ZERO;
        ADDR_W'(OFF_NVP):   begin st.wrNvp   = doWr; st.rdSel = RS_NVP;   end
        ADDR_W'(OFF_TACK):  st.rdTimerAck = doRd;
        ADDR_W'(OFF_SEVEN): st.rdSel = RS_SEVEN;
        ADDR_W'(OFF_IMR):   begin st.wrImr   = doWr; st.rdSel = RS_IMR;   end
        ADDR_W'(OFF_ISR):   st.rdSel = RS_ISR;
        default:            mapped = 1'b0;
      endcase
    end
    if (!mapped) st.rdSel = RS_ZERO;
    st.rdEn = doRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      rdValid   <= doRd;
      accessErr <= busValid && !mapped;
    end
  end

  // R2: every accepted read is answered in the next cycle
  assert_rdvalid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rdValid);

  // R9: the error strobe only follows an accepted access
  assert_err_follows_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(busValid));

endmodule

// File: rtl/ccr_dpath.sv
module ccr_dpath
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCH    = 8,
  parameter int LB_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NCH-1:0]    dmaFault,
  input  logic              timerEvent,
  output logic              timerIrq,
  input  logic [LB_W-1:0]   lbIrqIn,
  output logic              lbIrq,
  output logic              memWrReq,
  output logic [DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  localparam logic [DATA_W-1:0] ADDR_LSB_CLR = ~DATA_W'(1);

  logic [DATA_W-1:0] cfgQ, invQ, maintQ, ptagQ, ltagQ, bmaskQ, nvpQ, imrQ;
  logic [DATA_W-1:0] speedQ [SPEED_N];
  logic [NCH-1:0]    nmiQ;
  logic [LB_W-1:0]   isrQ;
  logic              winHit;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= DATA_W'(RST_CFG);
      invQ   <= '0;
      maintQ <= '0;
      ptagQ  <= '0;
      ltagQ  <= '0;
      bmaskQ <= '0;
      nvpQ   <= DATA_W'(RST_NVP);
      imrQ   <= DATA_W'(RST_IMR);
    end else begin
      if (st.wrCfg)   cfgQ   <= busWdata;
      if (st.wrInv)   invQ   <= busWdata;
      if (st.wrMaint) maintQ <= busWdata;
      if (st.wrPtag)  ptagQ  <= busWdata;
      if (st.wrLtag)  ltagQ  <= busWdata;
      if (st.wrBmask) bmaskQ <= busWdata;
      if (st.wrNvp)   nvpQ   <= busWdata;
      if (st.wrImr)   imrQ   <= busWdata;
    end
  end

  for (genvar i = 0; i < SPEED_N; i++) begin : g_speed
    always_ff @(posedge clk) begin
      if (!rstN)
        speedQ[i] <= DATA_W'(RST_SPEED);
      else if (st.wrSpeed && (st.speedIdx == SPEED_IW'(i)))
        speedQ[i] <= busWdata;
    end
  end

  // sticky NMI sources: a fault beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)
      nmiQ <= '0;
    else if (st.wrNmiClr)
      nmiQ <= (nmiQ & ~busWdata[NCH-1:0]) | dmaFault;
    else
      nmiQ <= nmiQ | dmaFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      timerIrq <= 1'b0;
    else if (timerEvent)
      timerIrq <= 1'b1;
    else if (st.rdTimerAck)
      timerIrq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) isrQ <= '0;
    else       isrQ <= lbIrqIn;
  end

  assign lbIrq = |({{(DATA_W-LB_W){1'b0}}, isrQ} & imrQ);

  // buffer-window write side effect
  assign winHit = st.wrWin && (ltagQ == DATA_W'(MAGIC_TAG)) && (bmaskQ == DATA_W'(MAGIC_MSK));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrReq  <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
    end else begin
      memWrReq <= winHit;
      if (winHit) begin
        memWrAddr <= (ptagQ & ADDR_LSB_CLR) + DATA_W'({maintQ[1:0], 3'b000});
        memWrData <= busWdata;
      end
    end
  end

  always_comb begin
    unique case (st.rdSel)
      RS_CFG:   rdNext = cfgQ;
      RS_REV:   rdNext = DATA_W'(RST_REV);
      RS_INV:   rdNext = invQ;
      RS_MAINT: rdNext = maintQ;
      RS_PTAG:  rdNext = ptagQ;
      RS_LTAG:  rdNext = ltagQ;
      RS_BMASK: rdNext = bmaskQ;
      RS_SPEED: rdNext = speedQ[st.speedIdx];
      RS_NMI:   rdNext = DATA_W'(nmiQ);
      RS_SEVEN: rdNext = DATA_W'(CONST_238);
      RS_NVP:   rdNext = nvpQ;
      RS_IMR:   rdNext = imrQ;
      RS_ISR:   rdNext = DATA_W'(isrQ);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         busRdata <= '0;
    else if (st.rdEn)  busRdata <= rdNext;
  end

  // R5: a request only follows a window write under the matching pairing
  assert_memreq_pairing_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> ($past(ltagQ) == DATA_W'(MAGIC_TAG)) && ($past(bmaskQ) == DATA_W'(MAGIC_MSK)));

  // R7: acknowledge without a new event leaves the interrupt low
  assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdTimerAck && !timerEvent) |=> !timerIrq);

  // R8: NMI bits are never lost without a clear write
  assert_nmi_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrNmiClr |=> ((nmiQ & $past(nmiQ)) == $past(nmiQ)));

  // R10: a sampled source under an enabled mask bit drives the output
  assert_lbirq_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((|(lbIrqIn & imrQ[LB_W-1:0])) && !st.wrImr) |=> lbIrq);

endmodule

// File: rtl/ccr_top.sv
module ccr_top
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int NCH    = 8,
  parameter int LB_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              rdValid,
  output logic              accessErr,
  input  logic [NCH-1:0]    dmaFault,
  input  logic              timerEvent,
  output logic              timerIrq,
  input  logic [LB_W-1:0]   lbIrqIn,
  output logic              lbIrq,
  output logic              memWrReq,
  output logic [DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  strobes_t st;

  ccr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .st(st), .rdValid(rdValid), .accessErr(accessErr)
  );

  ccr_dpath #(.DATA_W(DATA_W), .NCH(NCH), .LB_W(LB_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata), .busRdata(busRdata),
    .dmaFault(dmaFault), .timerEvent(timerEvent), .timerIrq(timerIrq),
    .lbIrqIn(lbIrqIn), .lbIrq(lbIrq), .memWrReq(memWrReq),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

endmodule

// File: tb/sim_ccr_top.sv
module sim_ccr_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rdValid, accessErr, timerIrq, lbIrq, memWrReq;
  logic [7:0]  dmaFault = '0;
  logic        timerEvent = 1'b0;
  logic [15:0] lbIrqIn = '0;
  logic [31:0] memWrAddr, memWrData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [31:0] expQ [$];
  string       reqQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_top u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rdValid(rdValid), .accessErr(accessErr), .dmaFault(dmaFault),
    .timerEvent(timerEvent), .timerIrq(timerIrq), .lbIrqIn(lbIrqIn),
    .lbIrq(lbIrq), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    access(1'b1, a, d);
  endtask

  // driver side of the scoreboard: push the expectation, then issue the read
  task automatic rd(logic [11:0] a, logic [31:0] e, string req);
    expQ.push_back(e);
    reqQ.push_back(req);
    access(1'b0, a, '0);
  endtask

  // monitor side: compare each returned read against the queue head
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected rdValid", busRdata, 32'h0);
      end else begin
        logic [31:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        chk(busRdata === e, r, busRdata, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(12'h000, 32'h410, "R1 config");
    rd(12'h008, 32'h1,   "R1 revision");
    rd(12'h220, 32'h7,   "R1 nvram protect");
    rd(12'h240, 32'h10,  "R1 irq mask");
    rd(12'h030, 32'h0,   "R1 maintenance");
    rd(12'h050, 32'h0,   "R1 logical tag");
    rd(12'h200, 32'h0,   "R1 nmi source");
    chk(timerIrq === 1'b0, "R1 timerIrq", {31'b0, timerIrq}, 32'h0);
    for (int i = 0; i < 16; i++) rd(12'h070 + 12'(i * 8), 32'h7, "R1 speed reset");

    // R2 write/read plus rdValid pulse width
    wr(12'h000, 32'h0000_0104);
    wr(12'h010, 32'hCAFE_0010);
    rd(12'h000, 32'h0000_0104, "R2 config");
    @(negedge clk);
    chk(rdValid === 1'b0, "R2 rdValid single cycle", {31'b0, rdValid}, 32'h0);
    rd(12'h010, 32'hCAFE_0010, "R2 invalid-address");

    // R3 sixteen distinct speed entries
    for (int i = 0; i < 16; i++) wr(12'h070 + 12'(i * 8), 32'h100 + 32'(i));
    for (int i = 0; i < 16; i++) rd(12'h070 + 12'(i * 8), 32'h100 + 32'(i), "R3 speed entry");

    // R4 read-only and constant locations
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, 32'h1, "R4 revision read-only");
    wr(12'h238, 32'h0);
    rd(12'h238, 32'h7, "R4 offset 0x238");
    rd(12'h208, 32'h0, "R4 offset 0x208");
    rd(12'h060, 32'h0, "R4 window read");

    // R5 / R6 window side effect
    wr(12'h050, 32'h8000_0001);
    wr(12'h058, 32'h0F0F_0F0F);
    wr(12'h048, 32'h0000_1235);
    wr(12'h030, 32'h0000_0006);
    wr(12'h060, 32'hDEAD_BEEF);
    chk(memWrReq === 1'b1, "R5 request", {31'b0, memWrReq}, 32'h1);
    chk(memWrData === 32'hDEAD_BEEF, "R5 data", memWrData, 32'hDEAD_BEEF);
    chk(memWrAddr === 32'h0000_1244, "R6 address", memWrAddr, 32'h0000_1244);
    @(negedge clk);
    chk(memWrReq === 1'b0, "R5 single pulse", {31'b0, memWrReq}, 32'h0);
    wr(12'h030, 32'h0000_0001);
    wr(12'h060, 32'h1234_5678);
    chk(memWrAddr === 32'h0000_123C, "R6 address index 1", memWrAddr, 32'h0000_123C);
    chk(memWrData === 32'h1234_5678, "R5 data 2", memWrData, 32'h1234_5678);
    wr(12'h058, 32'h0F0F_0F0E);
    wr(12'h060, 32'h1);
    chk(memWrReq === 1'b0, "R5 mask mismatch", {31'b0, memWrReq}, 32'h0);
    wr(12'h058, 32'h0F0F_0F0F);
    wr(12'h050, 32'h8000_0000);
    wr(12'h060, 32'h1);
    chk(memWrReq === 1'b0, "R5 tag mismatch", {31'b0, memWrReq}, 32'h0);

    // R7 timer interrupt
    @(negedge clk); timerEvent = 1'b1;
    @(negedge clk); timerEvent = 1'b0;
    chk(timerIrq === 1'b1, "R7 raise", {31'b0, timerIrq}, 32'h1);
    rd(12'h230, 32'h0, "R7 ack reads 0");
    chk(timerIrq === 1'b0, "R7 ack lowers", {31'b0, timerIrq}, 32'h0);
    @(negedge clk);
    busValid = 1'b1; busAddr = 12'h230; timerEvent = 1'b1;
    expQ.push_back(32'h0); reqQ.push_back("R7 ack with event");
    @(negedge clk);
    busValid = 1'b0; timerEvent = 1'b0;
    chk(timerIrq === 1'b1, "R7 event wins", {31'b0, timerIrq}, 32'h1);

    // R8 sticky NMI sources
    @(negedge clk); dmaFault = 8'h05;
    @(negedge clk); dmaFault = 8'h00;
    repeat (2) @(negedge clk);
    rd(12'h200, 32'h5, "R8 sticky bits");
    wr(12'h200, 32'h1);
    rd(12'h200, 32'h4, "R8 clear bit 0");
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 12'h200; busWdata = 32'h4; dmaFault = 8'h04;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; dmaFault = 8'h00;
    rd(12'h200, 32'h4, "R8 fault wins over clear");

    // R9 unmapped accesses
    rd(12'h100, 32'h0, "R9 unmapped read data");
    chk(accessErr === 1'b1, "R9 err on read", {31'b0, accessErr}, 32'h1);
    @(negedge clk);
    chk(accessErr === 1'b0, "R9 err one cycle", {31'b0, accessErr}, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    chk(accessErr === 1'b1, "R9 err misaligned write", {31'b0, accessErr}, 32'h1);
    rd(12'h000, 32'h0000_0104, "R9 config untouched");
    rd(12'h0F0, 32'h0, "R9 past last speed");
    chk(accessErr === 1'b1, "R9 err past speed", {31'b0, accessErr}, 32'h1);
    rd(12'h0E8, 32'h10F, "R9 last speed untouched");
    chk(accessErr === 1'b0, "R9 no err on mapped", {31'b0, accessErr}, 32'h0);

    // R10 masked local-bus interrupt
    @(negedge clk); lbIrqIn = 16'h0010;
    @(negedge clk);
    chk(lbIrq === 1'b1, "R10 enabled source", {31'b0, lbIrq}, 32'h1);
    rd(12'h248, 32'h10, "R10 source readback");
    lbIrqIn = 16'h0001;
    @(negedge clk);
    chk(lbIrq === 1'b0, "R10 masked source", {31'b0, lbIrq}, 32'h0);
    wr(12'h240, 32'h1);
    chk(lbIrq === 1'b1, "R10 mask update", {31'b0, lbIrq}, 32'h1);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2 all reads answered", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule